// File: doc/BRIEF.md
# Single-Wire Battery Gauge Bus Master

This block is the master side of a single-wire, open-drain serial link to a battery monitor. The host places a 7-bit register address, a direction flag and, for writes, one data byte on its inputs and pulses `req`. The block then runs one whole transaction on the wire. It drives a break, then a command byte. After that it either sends the data byte or releases the wire and decodes the byte that the monitor returns. At the end it raises `done` for one cycle, together with a result code and, after a successful read, the received byte.

Each bit travels as a low pulse inside a fixed-length cell, and the pulse length carries the value. The block never drives the wire high. It only asserts `line_oe`, which pulls the wire low, and an external pull-up restores the high level. All durations are counted in ticks of `tick_en`. One tick stands for `TICK_US` microseconds, and each duration becomes a tick count by integer division. At the default `TICK_US` of 10 these counts are: break 25, recovery 6, '1' low 5, '0' low 12, cell 21, write gap 30, response wait 250, first-bit low timeout 50, later-bit low timeout 40, high timeout 100 and '1' decode limit 6. The sampled wire passes through a two-flop synchronizer before the block measures it.

Top module: `swire_master`

## Requirements
- R1: After a synchronous reset, `line_oe`, `busy`, `done`, `err` and `rdata` are all 0.
- R2: A transaction opens with `line_oe` high for 25 ticks (250 µs). It is then low for 6 ticks (60 µs) before the first command bit.
- R3: The command byte is {wr, addr[6:0]}, so bit 7 = 1 means write and 0 means read. It is sent least significant bit first, as 8 cells.
- R4: Every transmitted cell lasts 21 ticks. A '1' holds `line_oe` high for 5 ticks and a '0' for 12 ticks. `line_oe` is low for the rest of the cell.
- R5: On a write, the wire stays released for 30 further ticks after the last command cell. The data byte latched at the request then goes out LSB first in the same cell coding, and the transaction ends with `err` = 0.
- R6: On a read, the block releases the wire after the command byte. If no low arrives within 250 ticks, the transaction ends with `err` = 1.
- R7: A received low of 6 ticks or fewer decodes as '1', and a longer low decodes as '0'. The first bit received becomes `rdata[0]`. After 8 bits the block ends with `err` = 0 and updates `rdata`, which changes at no other time.
- R8: A received low that outlasts its timeout ends the transaction with `err` = 2. The timeout is 50 ticks for the first bit and 40 ticks for later bits.
- R9: Waiting more than 100 ticks high for the next received bit ends the transaction with `err` = 3.
- R10: `busy` rises in the cycle after an accepted `req` and falls when `done` is asserted. A `req` that arrives while `busy` is high is ignored.
- R11: `done` is a single-cycle pulse. `line_oe` is 0 whenever `busy` is 0, after success and after every error.
- R12: The state advances only on cycles with `tick_en` high. With one tick every two cycles, every duration doubles in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle timing tick, worth TICK_US microseconds |
| req | input | 1 | Request pulse; accepted when not busy |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | 7 | Register address |
| wdata | input | 8 | Byte to write |
| line_in | input | 1 | Sampled level of the wire |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 no response, 2 low too long, 3 high too long |
| rdata | output | 8 | Last byte read successfully |

## Verification
Random reads and writes with arbitrary addresses and bytes check the command and data pulse trains cell by cell. They also check that random response lows on either side of the decode limit come back as the byte the bench's slave model sent. A directed read uses lows of exactly 6 and 7 ticks, which separates the inclusive '1' limit from an off-by-one. Three error reads tell the error codes apart: one gets no response, one gets a low held too long and one falls silent mid-byte, and each also shows that `rdata` keeps its old value. A write paced at half tick rate separates tick counting from cycle counting, and a second request issued mid-transaction shows that it neither changes the wire nor starts a later transaction.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BREAK,
        S_RECOV,
        S_TX_LOW,
        S_TX_HIGH,
        S_GAP,
        S_RX_WAIT,
        S_RX_LOW,
        S_RX_HIGH
    } st_e;

    // durations in microseconds
    localparam int BREAK_US    = 250;
    localparam int RECOV_US    = 60;
    localparam int ONE_LOW_US  = 50;
    localparam int ZERO_LOW_US = 120;
    localparam int CELL_US     = 210;
    localparam int WGAP_US     = 300;
    localparam int RWAIT_US    = 2500;
    localparam int RFIRST_US   = 500;
    localparam int RLOW_US     = 400;
    localparam int RHIGH_US    = 1000;
    localparam int ONE_MAX_US  = 65;

    localparam logic [1:0] ERR_OK     = 2'd0;
    localparam logic [1:0] ERR_NORESP = 2'd1;
    localparam logic [1:0] ERR_LOWTO  = 2'd2;
    localparam logic [1:0] ERR_HIGHTO = 2'd3;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swire_tx_cell.sv
module swire_tx_cell #(
    parameter int CW     = 8,
    parameter int ONE_T  = 5,
    parameter int ZERO_T = 12,
    parameter int CELL_T = 21
) (
    input  logic          bit_i,
    output logic [CW-1:0] low_o,
    output logic [CW-1:0] high_o
);
    localparam logic [CW-1:0] ONE_L  = CW'(ONE_T);
    localparam logic [CW-1:0] ZERO_L = CW'(ZERO_T);
    localparam logic [CW-1:0] ONE_H  = CW'(CELL_T - ONE_T);
    localparam logic [CW-1:0] ZERO_H = CW'(CELL_T - ZERO_T);

    always_comb begin
        low_o  = bit_i ? ONE_L : ZERO_L;
        high_o = bit_i ? ONE_H : ZERO_H;
    end
endmodule

// File: rtl/swire_rx_bit.sv
module swire_rx_bit #(
    parameter int CW        = 8,
    parameter int ONE_MAX_T = 6
) (
    input  logic [CW-1:0] lcnt_i,
    output logic          bit_o
);
    assign bit_o = (lcnt_i <= CW'(ONE_MAX_T));
endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int TICK_US = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       req,
    input  logic       wr,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    input  logic       line_in,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic [1:0] err,
    output logic [7:0] rdata
);
    localparam int BRK_T   = BREAK_US / TICK_US;
    localparam int REC_T   = RECOV_US / TICK_US;
    localparam int ONE_T   = ONE_LOW_US / TICK_US;
    localparam int ZERO_T  = ZERO_LOW_US / TICK_US;
    localparam int CELL_T  = CELL_US / TICK_US;
    localparam int GAP_T   = WGAP_US / TICK_US;
    localparam int WAIT_T  = RWAIT_US / TICK_US;
    localparam int FIRST_T = RFIRST_US / TICK_US;
    localparam int LOWTO_T = RLOW_US / TICK_US;
    localparam int HIGH_T  = RHIGH_US / TICK_US;
    localparam int OMAX_T  = ONE_MAX_US / TICK_US;
    localparam int CW      = $clog2(WAIT_T + 1);

    typedef struct packed {
        st_e          st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] aux;
        logic [7:0]   sh;
        logic [3:0]   nbit;
        logic         data_ph;
        logic [7:0]   cmd;
        logic [7:0]   wbyte;
        logic [7:0]   rx;
        logic         oe;
        logic         req_tag;
        logic         ack_tag;
        logic         done;
        logic [1:0]   err;
        logic [7:0]   rdata;
    } regs_t;

    regs_t q, d;

    logic          line_s;
    logic [CW-1:0] cell_low, cell_high;
    logic          rx_bit;
    logic          last;
    logic          go_cell;
    logic          finish;
    logic [1:0]    fin_code;

    swire_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_in),
        .q_o (line_s)
    );

    swire_tx_cell #(
        .CW(CW), .ONE_T(ONE_T), .ZERO_T(ZERO_T), .CELL_T(CELL_T)
    ) u_cell (
        .bit_i  (q.sh[0]),
        .low_o  (cell_low),
        .high_o (cell_high)
    );

    swire_rx_bit #(.CW(CW), .ONE_MAX_T(OMAX_T)) u_rxbit (
        .lcnt_i (q.aux),
        .bit_o  (rx_bit)
    );

    assign last = (q.cnt == CW'(1));

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        go_cell  = 1'b0;
        finish   = 1'b0;
        fin_code = ERR_OK;

        // accept a request only when no transaction is pending
        if (req && (q.req_tag == q.ack_tag)) begin
            d.req_tag = ~q.req_tag;
            d.cmd     = {wr, addr};
            d.wbyte   = wdata;
        end

        if (tick_en) begin
            unique case (q.st)
                S_IDLE: begin
                    if (q.req_tag != q.ack_tag) begin
                        d.st  = S_BREAK;
                        d.cnt = CW'(BRK_T);
                        d.oe  = 1'b1;
                    end
                end
                S_BREAK: begin
                    if (last) begin
                        d.st      = S_RECOV;
                        d.cnt     = CW'(REC_T);
                        d.oe      = 1'b0;
                        d.sh      = q.cmd;
                        d.nbit    = 4'd8;
                        d.data_ph = 1'b0;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                S_RECOV, S_GAP: begin
                    if (last) go_cell = 1'b1;
                    else      d.cnt   = q.cnt - 1'b1;
                end
                S_TX_LOW: begin
                    if (last) begin
                        d.st  = S_TX_HIGH;
                        d.cnt = q.aux;
                        d.oe  = 1'b0;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                S_TX_HIGH: begin
                    if (!last) begin
                        d.cnt = q.cnt - 1'b1;
                    end else if (q.nbit != 4'd0) begin
                        go_cell = 1'b1;
                    end else if (q.data_ph) begin
                        finish = 1'b1;
                    end else if (q.cmd[7]) begin
                        d.st      = S_GAP;
                        d.cnt     = CW'(GAP_T);
                        d.sh      = q.wbyte;
                        d.nbit    = 4'd8;
                        d.data_ph = 1'b1;
                    end else begin
                        d.st   = S_RX_WAIT;
                        d.cnt  = CW'(WAIT_T);
                        d.nbit = 4'd8;
                    end
                end
                S_RX_WAIT: begin
                    if (!line_s) begin
                        d.st  = S_RX_LOW;
                        d.aux = CW'(1);
                        d.cnt = CW'(FIRST_T);
                    end else if (last) begin
                        finish   = 1'b1;
                        fin_code = ERR_NORESP;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                S_RX_LOW: begin
                    if (line_s) begin
                        d.rx = {rx_bit, q.rx[7:1]};
                        if (q.nbit == 4'd1) begin
                            finish  = 1'b1;
                            d.rdata = {rx_bit, q.rx[7:1]};
                        end else begin
                            d.nbit = q.nbit - 4'd1;
                            d.st   = S_RX_HIGH;
                            d.cnt  = CW'(HIGH_T);
                        end
                    end else begin
                        d.aux = q.aux + 1'b1;
                        if (last) begin
                            finish   = 1'b1;
                            fin_code = ERR_LOWTO;
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                        end
                    end
                end
                S_RX_HIGH: begin
                    if (!line_s) begin
                        d.st  = S_RX_LOW;
                        d.aux = CW'(1);
                        d.cnt = CW'(LOWTO_T);
                    end else if (last) begin
                        finish   = 1'b1;
                        fin_code = ERR_HIGHTO;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end

        if (go_cell) begin
            d.st   = S_TX_LOW;
            d.cnt  = cell_low;
            d.aux  = cell_high;
            d.oe   = 1'b1;
            d.sh   = q.sh >> 1;
            d.nbit = q.nbit - 4'd1;
        end

        if (finish) begin
            d.st      = S_IDLE;
            d.oe      = 1'b0;
            d.ack_tag = q.req_tag;
            d.done    = 1'b1;
            d.err     = fin_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign line_oe = q.oe;
    assign busy    = q.req_tag ^ q.ack_tag;
    assign done    = q.done;
    assign err     = q.err;
    assign rdata   = q.rdata;
endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       tick_en,
    input logic       line_oe,
    input logic       busy,
    input logic       done,
    input logic [1:0] err,
    input logic [7:0] rdata
);
    p_idle_released_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_oe);

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_from_req_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

    p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(line_oe) && !done));

    p_err_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(err) |-> done);

    p_rdata_on_ok_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> (done && err == 2'd0));
endmodule

bind swire_master swire_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .tick_en (tick_en),
    .line_oe (line_oe),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rdata   (rdata)
);

// File: tb/swire_master_bench.sv
module swire_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       line_in;
    logic       line_oe, busy, done;
    logic [1:0] err;
    logic [7:0] rdata;
    logic       slave_low = 1'b0;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tph = 0;
    bit mon_clr = 1'b0;
    int npulse = 0, run_lo = 0, run_hi = 0;
    int plen [0:31];
    int hlen [0:31];
    int done_cnt = 0;
    logic [7:0] exp_rdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = ~(line_oe | slave_low);

    swire_master u_swire_master (
        .clk(clk), .rst(rst), .tick_en(tick_en), .req(req), .wr(wr),
        .addr(addr), .wdata(wdata), .line_in(line_in), .line_oe(line_oe),
        .busy(busy), .done(done), .err(err), .rdata(rdata)
    );

    always @(negedge clk) begin
        tph     = (tph + 1) % tick_div;
        tick_en = (tph == 0);
    end

    always @(negedge clk) if (done) done_cnt++;

    always @(negedge clk) begin
        if (mon_clr) begin
            npulse = 0; run_lo = 0; run_hi = 0;
        end else if (line_oe) begin
            if (run_hi > 0 && npulse > 0 && npulse <= 32) hlen[npulse-1] = run_hi;
            run_hi = 0;
            run_lo++;
        end else begin
            if (run_lo > 0) begin
                if (npulse < 32) plen[npulse] = run_lo;
                npulse++;
                run_lo = 0;
            end
            run_hi++;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int low_of(input logic b);
        return b ? 5 : 12;
    endfunction

    // mode: 0 slave answers, 1 no answer, 2 stuck low, 3 stops after 3 bits
    task automatic run_tx(input logic w, input logic [6:0] a, input logic [7:0] dv,
                          input int mode, input logic [7:0] rb, input int div,
                          input bit edge_len, input bit inject);
        logic [7:0] cmdb;
        int dc0, t, bad, expn;
        logic [1:0] exp_err;
        cmdb = {w, a};
        tick_div = div;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        dc0 = done_cnt;
        req = 1'b1; wr = w; addr = a; wdata = dv;
        @(negedge clk);
        req = 1'b0; wr = 1'($urandom); addr = 7'($urandom); wdata = 8'($urandom);
        if (inject) begin
            repeat (200) @(negedge clk);
            req = 1'b1; wr = ~w; addr = ~a; wdata = ~dv;
            @(negedge clk);
            req = 1'b0;
        end
        if (!w) begin
            t = 0;
            while (npulse < 9 && t < 20000) begin @(negedge clk); t++; end
            repeat (30) @(negedge clk);
            if (mode == 0 || mode == 3) begin
                for (int i = 0; i < ((mode == 3) ? 3 : 8); i++) begin
                    int len;
                    if (rb[i]) len = edge_len ? 6 : 3 + int'($urandom % 4);
                    else       len = edge_len ? 7 : 7 + int'($urandom % 14);
                    slave_low = 1'b1;
                    repeat (len) @(negedge clk);
                    slave_low = 1'b0;
                    repeat (2 + int'($urandom % 20)) @(negedge clk);
                end
            end else if (mode == 2) begin
                slave_low = 1'b1;
                repeat (80) @(negedge clk);
                slave_low = 1'b0;
            end
        end
        t = 0;
        while (done_cnt == dc0 && t < 20000) begin @(negedge clk); t++; end
        chk(done_cnt == dc0 + 1, "R11 one done per request", done_cnt - dc0, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy cleared at completion", int'(busy), 0);
        chk(line_oe == 1'b0, "R11 line released after completion", int'(line_oe), 0);
        expn = w ? 17 : 9;
        chk(npulse == expn, "R3 pulse count", npulse, expn);
        chk(plen[0] == 25 * div, "R2 R12 break length", plen[0], 25 * div);
        chk(hlen[0] == 6 * div, "R2 R12 recovery length", hlen[0], 6 * div);
        bad = 0;
        for (int i = 0; i < 8; i++)
            if (plen[1+i] != low_of(cmdb[i]) * div) bad++;
        chk(bad == 0, "R3 R4 command cell lows", bad, 0);
        chk(plen[1] + hlen[1] == 21 * div, "R4 cell length", plen[1] + hlen[1], 21 * div);
        if (w) begin
            bad = 0;
            for (int i = 0; i < 8; i++)
                if (plen[9+i] != low_of(dv[i]) * div) bad++;
            chk(bad == 0, "R5 data cell lows", bad, 0);
            chk(hlen[8] == (21 - low_of(cmdb[7]) + 30) * div, "R5 write gap",
                hlen[8], (21 - low_of(cmdb[7]) + 30) * div);
            exp_err = 2'd0;
        end else begin
            case (mode)
                0: begin exp_err = 2'd0; exp_rdata = rb; end
                1: exp_err = 2'd1;
                2: exp_err = 2'd2;
                default: exp_err = 2'd3;
            endcase
        end
        chk(err == exp_err, "R5 R6 R8 R9 error code", int'(err), int'(exp_err));
        chk(rdata == exp_rdata, "R7 received byte", int'(rdata), int'(exp_rdata));
        if (inject) begin
            repeat (400) @(negedge clk);
            chk(npulse == expn && !busy, "R10 request while busy ignored", npulse, expn);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(line_oe == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs",
            int'({line_oe, busy, done}), 0);
        chk(err == 2'd0 && rdata == 8'h00, "R1 reset result", int'({err, rdata}), 0);

        // directed corners
        run_tx(1'b1, 7'h7f, 8'h00, 0, 8'h00, 1, 1'b0, 1'b0);
        run_tx(1'b0, 7'h00, 8'h00, 0, 8'hA5, 1, 1'b1, 1'b0); // R7 boundary lows 6 and 7
        run_tx(1'b0, 7'h12, 8'h00, 1, 8'h00, 1, 1'b0, 1'b0); // R6 no response
        run_tx(1'b0, 7'h34, 8'h00, 2, 8'h00, 1, 1'b0, 1'b0); // R8 stuck low
        run_tx(1'b0, 7'h56, 8'h00, 3, 8'hFF, 1, 1'b0, 1'b0); // R9 silence mid-byte
        run_tx(1'b1, 7'h2b, 8'hC3, 0, 8'h00, 2, 1'b0, 1'b0); // R12 half-rate ticks
        run_tx(1'b1, 7'h41, 8'h9e, 0, 8'h00, 1, 1'b0, 1'b1); // R10 request while busy

        for (int k = 0; k < 14; k++) begin
            run_tx(1'($urandom), 7'($urandom), 8'($urandom), 0, 8'($urandom), 1, 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule